// File: doc/BRIEF.md
# Dual-Read Register File

This block stores thirty-two 32-bit words and gives two consumers independent, unclocked views of them. Each read port takes a 5-bit register number and its output follows the addressed register combinationally. When the number or the stored word changes, the output changes in the same time step.

Writes do not use a free-running clock. A dedicated write strobe is used instead, and its falling edge commits the 32-bit write data into the register named by the 5-bit write number. The write number and data must be stable around that edge. A synchronous active-high clear is sampled on the same falling edge and zeroes every register. Two reads and one write can proceed together. A read of the register being written shows the old word until the falling edge and the new word after it.

Top module: `regfile_dual_rd`

## Requirements
- R1: The block holds 32 registers of 32 bits. A read port whose number is n returns the word last stored into register n, for every n from 0 to 31.
- R2: Read port A output changes to the addressed register's value when rdNumA changes, with no strobe edge.
- R3: Read port B works independently of port A. When both ports select the same register, both return its value.
- R4: On a falling edge of wrStrobe with rst low, wrData is stored into register wrNum. A rising edge of wrStrobe stores nothing.
- R5: On a falling edge of wrStrobe with rst high, all 32 registers become zero and the write on that edge is ignored.
- R6: A write changes only the register named by wrNum. Every other register keeps its value.
- R7: A read of the register being written returns the old value while the strobe is high and the new value once the strobe has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrStrobe | input | 1 | Write strobe; falling edge commits a write or a clear |
| rst | input | 1 | Synchronous clear, active high, sampled on the strobe's falling edge |
| wrNum | input | 5 | Number of the register to write |
| wrData | input | 32 | Word to store |
| rdNumA | input | 5 | Register number for read port A |
| rdNumB | input | 5 | Register number for read port B |
| rdDataA | output | 32 | Contents of register rdNumA |
| rdDataB | output | 32 | Contents of register rdNumB |

## Verification
The hardest situation to observe is the window in which the strobe is high, the write data is already on the pins, and a read port points at the target register. The output must still show the old word there (R7). The stimulus raises the strobe with a fresh word, samples both ports before lowering it, and samples again after the fall. Random writes of random words, with random read numbers that often coincide on both ports, check that no other register is disturbed. A clear pulse is issued mid-run with a live write pending, which checks that the clear overrides that write.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int REG_COUNT  = 32;
  localparam int DATA_W     = 32;
  localparam int NUM_W      = $clog2(REG_COUNT);
  localparam int READ_PORTS = 2;

  typedef struct packed {
    logic                 clearAll;
    logic [REG_COUNT-1:0] wrSel;
  } wrCtl_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic             wrStrobe,
  input  logic             rst,
  input  logic [NUM_W-1:0] wrNum,
  output wrCtl_t           ctl
);
  always_comb begin
    ctl.clearAll = rst;
    ctl.wrSel    = '0;
    if (!rst) ctl.wrSel[wrNum] = 1'b1;
  end

  // R6: exactly one register is targeted by any write edge
  p_single_target_r6: assert property (@(negedge wrStrobe) disable iff (rst)
    $countones(ctl.wrSel) == 1);
endmodule

// File: rtl/regfile_store.sv
module regfile_store
  import regfile_pkg::*;
(
  input  logic                             wrStrobe,
  input  wrCtl_t                           ctl,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [READ_PORTS-1:0][NUM_W-1:0] rdNum,
  output logic [READ_PORTS-1:0][DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] storage [REG_COUNT];

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
    always_ff @(negedge wrStrobe) begin
      if (ctl.clearAll)      storage[r] <= '0;
      else if (ctl.wrSel[r]) storage[r] <= wrData;
    end

    // R4: a selected register holds the data from the previous write edge
    p_write_lands_r4: assert property (@(negedge wrStrobe) disable iff (ctl.clearAll)
      (!$past(ctl.clearAll) && $past(ctl.wrSel[r])) |-> storage[r] == $past(wrData));

    // R6: an unselected register keeps its value across a write edge
    p_keep_others_r6: assert property (@(negedge wrStrobe) disable iff (ctl.clearAll)
      (!$past(ctl.clearAll) && !$past(ctl.wrSel[r])) |-> storage[r] == $past(storage[r]));

    // R5: a clear edge leaves every register at zero
    p_cleared_r5: assert property (@(negedge wrStrobe) disable iff (ctl.clearAll)
      $past(ctl.clearAll) |-> storage[r] == '0);
  end

  for (genvar p = 0; p < READ_PORTS; p++) begin : g_rd
    assign rdData[p] = storage[rdNum[p]];
  end
endmodule

// File: rtl/regfile_dual_rd.sv
module regfile_dual_rd
  import regfile_pkg::*;
(
  input  logic              wrStrobe,
  input  logic              rst,
  input  logic [NUM_W-1:0]  wrNum,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_W-1:0]  rdNumA,
  input  logic [NUM_W-1:0]  rdNumB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  wrCtl_t                            ctl;
  logic [READ_PORTS-1:0][NUM_W-1:0]  rdNum;
  logic [READ_PORTS-1:0][DATA_W-1:0] rdData;

  assign rdNum[0] = rdNumA;
  assign rdNum[1] = rdNumB;
  assign rdDataA  = rdData[0];
  assign rdDataB  = rdData[1];

  regfile_ctrl i_ctrl (
    .wrStrobe(wrStrobe),
    .rst     (rst),
    .wrNum   (wrNum),
    .ctl     (ctl)
  );

  regfile_store i_store (
    .wrStrobe(wrStrobe),
    .ctl     (ctl),
    .wrData  (wrData),
    .rdNum   (rdNum),
    .rdData  (rdData)
  );
endmodule

// File: tb/test_regfile_dual_rd.sv
module test_regfile_dual_rd;
  logic        clk = 1'b0;
  logic        wrStrobe = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  wrNum = '0, rdNumA = '0, rdNumB = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;
  logic [31:0] model [32];
  int          testCount = 0;
  int          failCount = 0;
  int unsigned seedDummy;

  always #2 clk = ~clk;

  regfile_dual_rd i_regfile_dual_rd (
    .wrStrobe(wrStrobe), .rst(rst), .wrNum(wrNum), .wrData(wrData),
    .rdNumA(rdNumA), .rdNumB(rdNumB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  function automatic logic [31:0] expectRead(input logic [4:0] n);
    return model[n];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobeWrite(input logic [4:0] n, input logic [31:0] d);
    wrNum = n; wrData = d;
    #1 wrStrobe = 1'b1;
    #2 wrStrobe = 1'b0;
    #1;
    if (rst) for (int i = 0; i < 32; i++) model[i] = '0;
    else model[n] = d;
  endtask

  task automatic readBoth(input string tag, input logic [4:0] a, input logic [4:0] b);
    rdNumA = a; rdNumB = b;
    #1;
    check({tag, " portA"}, rdDataA, expectRead(a));
    check({tag, " portB"}, rdDataB, expectRead(b));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'h5eed);
    // R5: clear on a strobe fall with rst high
    strobeWrite(5'd3, 32'hDEAD_BEEF);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) readBoth("R5 reset state", 5'(i), 5'(31 - i));

    // R1 R4: fill every register, read all back
    for (int i = 0; i < 32; i++) strobeWrite(5'(i), $urandom);
    for (int i = 0; i < 32; i++) readBoth("R1 full fill", 5'(i), 5'(i ^ 5));

    // R2: port A follows its number without a strobe
    for (int i = 0; i < 8; i++) begin
      rdNumA = 5'($urandom); #1;
      check("R2 comb read A", rdDataA, expectRead(rdNumA));
    end

    // R3 R6: random writes; ports often on the same register
    for (int k = 0; k < 300; k++) begin
      logic [4:0] a;
      strobeWrite(5'($urandom), $urandom);
      a = 5'($urandom);
      if (k % 3 == 0) readBoth("R3 same register", a, a);
      else readBoth("R6 random read", a, 5'($urandom));
    end

    // R7 and R4 rising edge: old value while strobe high, new after fall
    for (int k = 0; k < 6; k++) begin
      logic [4:0]  n;
      logic [31:0] d;
      n = (k == 0) ? 5'd0 : (k == 1) ? 5'd31 : 5'($urandom);
      d = $urandom;
      rdNumA = n; rdNumB = n; wrNum = n; wrData = d;
      #1 wrStrobe = 1'b1;
      #1;
      check("R7 old while high A", rdDataA, model[n]);
      check("R4 rise stores nothing B", rdDataB, model[n]);
      #1 wrStrobe = 1'b0;
      #1;
      model[n] = d;
      check("R7 new after fall A", rdDataA, d);
      check("R7 new after fall B", rdDataB, d);
    end

    // R5: mid-run clear overrides a pending write
    rst = 1'b1;
    strobeWrite(5'd9, 32'h1234_5678);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) readBoth("R5 mid-run clear", 5'(i), 5'(i));

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule